// File: doc/BRIEF.md
# Address Translation Cache With Flush

This block caches recent logical-to-physical page translations for a processor's memory management unit. It holds two direct-mapped banks, one for user accesses and one for supervisor accesses, each with 64 entries. The entry index comes from logical address bits [17:12]. The tag holds the remaining upper bits, and a reserved tag value marks an empty entry. Each entry keeps a page offset and six flags: global, modified, write-protect, transparent, valid-for-data and valid-for-instructions.

A request that finds a usable entry is answered on the cycle after it is accepted. The physical address is the logical address plus the stored offset. On a miss, the block raises a level request to an external table walker. The walker returns either a transparent-window match (with a write-protect flag and a flag saying whether the window also covers the other access type) or a page descriptor. The block fills the entry from that answer, checks it again, and responds.

Software maintenance is done through two inputs. A flush can target one address in one bank, or every entry in both banks. Either kind can optionally spare entries marked global. A write to the translation-control input sets paging enable and page size, and flushes everything.

Top module: `xlate_cache`

## Requirements
- R1: After reset every entry is empty, paging is disabled, the page size is 4 KiB and `req_ready` is 1; the first access to any address asks the walker.
- R2: On a miss, `walk_req` rises and stays high until `walk_done`, presenting the request's address, privilege, data/instruction and write flags; `req_ready` is 0 while a walk is pending.
- R3: A request that finds a usable entry gives `resp_valid` one cycle after acceptance, with `resp_hit`=1, no walk and `resp_phys` = logical address + stored offset.
- R4: With paging disabled (and no window match), a fill makes the entry usable for data and instruction reads and writes with `resp_phys` equal to the logical address.
- R5: A window match (`walk_win_hit`=1) fills with zero offset and with modified and global set. A write to a window with `walk_win_wp`=1 faults. The other access type is valid only when `walk_win_other`=1.
- R6: A descriptor fill stores offset = (descriptor page) − (logical page), where the page is bits [31:12] for 4 KiB and bits [31:13] for 8 KiB. Descriptor fields are: bit 0 resident, bit 2 write-protect, bit 4 modified, bit 7 supervisor-only, bit 10 global.
- R7: A non-resident descriptor, or a supervisor-only page reached by a user access, gives `resp_fault`=1 with `resp_phys`=0.
- R8: A write that hits a write-protected entry faults without a walk.
- R9: A write that hits an entry whose modified flag is clear walks again and then completes.
- R10: A flush by address (`flush_all`=0) empties the entry at that address's index in the bank chosen by `flush_super`. A global entry is emptied only when `flush_global`=1.
- R11: In 8 KiB mode, a flush by address also applies the same rule to the entry at the index XOR 1.
- R12: A flush with `flush_all`=1 applies the global rule to every entry of both banks.
- R13: `tc_wr` loads paging enable from `tc_wdata[15]` and 8 KiB page size from `tc_wdata[14]`, and empties all entries, global ones included.
- R14: User and supervisor banks are separate. A fill or flush in one bank does not change the other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tc_wr | input | 1 | Translation-control write strobe (honoured when idle) |
| tc_wdata | input | 16 | Control value: bit 15 paging enable, bit 14 8 KiB pages |
| flush_valid | input | 1 | Flush strobe (honoured when idle, no tc_wr) |
| flush_all | input | 1 | 1: flush both banks entirely; 0: flush by address |
| flush_global | input | 1 | 1: global entries are flushed too |
| flush_super | input | 1 | Bank selected by a flush by address (1 = supervisor) |
| flush_addr | input | 32 | Logical address for a flush by address |
| req_valid | input | 1 | Translation request |
| req_ready | output | 1 | Block idle and able to accept a request |
| req_addr | input | 32 | Logical address |
| req_super | input | 1 | Supervisor access |
| req_data | input | 1 | 1 data access, 0 instruction fetch |
| req_write | input | 1 | Write access |
| resp_valid | output | 1 | One-cycle response pulse |
| resp_hit | output | 1 | Response produced without a walk |
| resp_fault | output | 1 | Access refused |
| resp_phys | output | 32 | Physical address (0 on fault) |
| walk_req | output | 1 | Walk request, held until walk_done |
| walk_addr | output | 32 | Address to walk |
| walk_super | output | 1 | Privilege of the walk |
| walk_data | output | 1 | Data/instruction type of the walk |
| walk_write | output | 1 | Walk is for a write |
| walk_done | input | 1 | Walker result valid |
| walk_win_hit | input | 1 | Transparent window matched |
| walk_win_wp | input | 1 | Matching window is write-protected |
| walk_win_other | input | 1 | Window also matches the other access type |
| walk_desc | input | 32 | Page descriptor from the table walk |

## Verification
On every cycle, the assertions check several rules: the walk handshake is held, no request is accepted while walking, a fault never carries an address, and a hit response follows exactly one lookup cycle. They also check that a translation-control write leaves every entry empty, and that a flush sparing globals leaves every valid global entry's tag unchanged. Other behaviours can only be shown by the bench's directed scenarios. These are the offset arithmetic in both page sizes, the fault rules for write-protect, residency and privilege, the refill on writes to unmodified pages, and the selection made by each flush: own bank versus other bank, and the neighbour index in 8 KiB mode.

// File: rtl/xlc_pkg.sv
package xlc_pkg;
  localparam int XLC_AW       = 32;
  localparam int XLC_IDX_W    = 6;
  localparam int XLC_PG_SHIFT = 12;
  localparam int XLC_TAG_W    = 16;
  localparam int XLC_PN_W     = XLC_AW - XLC_PG_SHIFT;
  localparam int XLC_NENT     = 1 << XLC_IDX_W;

  localparam logic [XLC_TAG_W-1:0] XLC_TAG_EMPTY = 16'h8000;

  // descriptor field positions decoded from the walker's answer
  localparam int D_RES = 0;
  localparam int D_WP  = 2;
  localparam int D_MOD = 4;
  localparam int D_SUP = 7;
  localparam int D_GLB = 10;

  typedef struct packed {
    logic [XLC_TAG_W-1:0] tag;
    logic [XLC_PN_W-1:0]  off;
    logic                 glob;
    logic                 mod;
    logic                 wp;
    logic                 tt;
    logic                 vd;
    logic                 vi;
  } xlc_entry_t;

  localparam xlc_entry_t XLC_ENT_EMPTY =
    xlc_entry_t'({XLC_TAG_EMPTY, {(XLC_PN_W + 6){1'b0}}});

  typedef enum logic [1:0] {XS_IDLE, XS_LOOK, XS_WALK} xlc_state_e;

  function automatic logic [XLC_TAG_W-1:0] xlc_tag_of(input logic [XLC_PN_W-1:0] pn);
    return XLC_TAG_W'(pn[XLC_PN_W-1:XLC_IDX_W]);
  endfunction
endpackage

// File: rtl/xlc_fill.sv
module xlc_fill
  import xlc_pkg::*;
(
  input  logic                paging_on,
  input  logic                page8k,
  input  logic                is_super,
  input  logic                is_data,
  input  logic [XLC_PN_W-1:0] lpn,
  input  logic                win_hit,
  input  logic                win_wp,
  input  logic                win_other,
  input  logic [XLC_AW-1:0]   desc,
  output xlc_entry_t          ent
);
  logic [XLC_PN_W-1:0] pmask, phys_pg, log_pg;
  logic unused_desc;
  assign unused_desc = ^{desc[XLC_PG_SHIFT-1:D_GLB+1], desc[D_GLB-1:D_SUP+1],
                         desc[D_SUP-1:D_MOD+1], desc[D_WP+1], desc[D_WP-1:D_RES+1]};

  assign pmask   = {{(XLC_PN_W-1){1'b1}}, ~page8k};
  assign phys_pg = desc[XLC_AW-1:XLC_PG_SHIFT] & pmask;
  assign log_pg  = lpn & pmask;

  always_comb begin
    ent     = '0;
    ent.tag = xlc_tag_of(lpn);
    if (win_hit) begin
      ent.tt   = 1'b1;
      ent.vd   = is_data | win_other;
      ent.vi   = ~is_data | win_other;
      ent.glob = 1'b1;
      ent.mod  = 1'b1;
      ent.wp   = win_wp;
    end else if (!paging_on) begin
      ent.vd   = 1'b1;
      ent.vi   = 1'b1;
      ent.glob = 1'b1;
      ent.mod  = 1'b1;
    end else if (desc[D_RES] && !(desc[D_SUP] && !is_super)) begin
      ent.vd   = 1'b1;
      ent.vi   = 1'b1;
      ent.off  = phys_pg - log_pg;
      ent.glob = desc[D_GLB];
      ent.mod  = desc[D_MOD];
      ent.wp   = desc[D_WP];
    end
  end
endmodule

// File: rtl/xlc_probe.sv
module xlc_probe
  import xlc_pkg::*;
(
  input  xlc_entry_t        ent,
  input  logic [XLC_AW-1:0] addr,
  input  logic              is_data,
  input  logic              is_write,
  output logic              done_ok,
  output logic              done_fault,
  output logic [XLC_AW-1:0] phys
);
  logic match, usable, wr_block, unused_tt;
  assign unused_tt  = ent.tt;
  assign match      = (ent.tag == xlc_tag_of(addr[XLC_AW-1:XLC_PG_SHIFT]));
  assign usable     = is_data ? ent.vd : ent.vi;
  assign wr_block   = is_write & ent.wp;
  assign done_fault = match & (~usable | wr_block);
  assign done_ok    = match & usable & ~wr_block & ~(is_write & ~ent.mod);
  assign phys       = {addr[XLC_AW-1:XLC_PG_SHIFT] + ent.off, addr[XLC_PG_SHIFT-1:0]};
endmodule

// File: rtl/xlc_flush_mask.sv
module xlc_flush_mask #(
  parameter int IDX_W = 6,
  localparam int N    = 1 << IDX_W
) (
  input  logic                apply,
  input  logic                all,
  input  logic                with_glob,
  input  logic                bank,
  input  logic [IDX_W-1:0]    idx,
  input  logic                page8k,
  input  logic [1:0][N-1:0]   glob,
  output logic [1:0][N-1:0]   clr
);
  logic [IDX_W-1:0] idx_pair;
  assign idx_pair = idx ^ IDX_W'(1);

  for (genvar b = 0; b < 2; b++) begin : g_bank
    for (genvar i = 0; i < N; i++) begin : g_ent
      logic sel;
      assign sel = all | ((bank == 1'(b)) &
                   ((idx == IDX_W'(i)) | (page8k & (idx_pair == IDX_W'(i)))));
      assign clr[b][i] = apply & sel & (with_glob | ~glob[b][i]);
    end
  end
endmodule

// File: rtl/xlate_cache.sv
module xlate_cache
  import xlc_pkg::*;
#(
  parameter int AW    = XLC_AW,
  parameter int IDX_W = XLC_IDX_W,
  localparam int N    = 1 << IDX_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tc_wr,
  input  logic [15:0]   tc_wdata,
  input  logic          flush_valid,
  input  logic          flush_all,
  input  logic          flush_global,
  input  logic          flush_super,
  input  logic [AW-1:0] flush_addr,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [AW-1:0] req_addr,
  input  logic          req_super,
  input  logic          req_data,
  input  logic          req_write,
  output logic          resp_valid,
  output logic          resp_hit,
  output logic          resp_fault,
  output logic [AW-1:0] resp_phys,
  output logic          walk_req,
  output logic [AW-1:0] walk_addr,
  output logic          walk_super,
  output logic          walk_data,
  output logic          walk_write,
  input  logic          walk_done,
  input  logic          walk_win_hit,
  input  logic          walk_win_wp,
  input  logic          walk_win_other,
  input  logic [AW-1:0] walk_desc
);
  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_sync_q;
  logic       rst_n_s;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_s = rst_sync_q[1];

  xlc_state_e    state_q, state_d;
  logic [AW-1:0] rq_addr_q, rq_addr_d;
  logic          rq_super_q, rq_super_d, rq_data_q, rq_data_d, rq_write_q, rq_write_d;
  logic          walked_q, walked_d, paging_q, paging_d, p8_q, p8_d;
  logic          rsp_v_q, rsp_v_d, rsp_hit_q, rsp_hit_d, rsp_flt_q, rsp_flt_d;
  logic [AW-1:0] rsp_phys_q, rsp_phys_d;
  xlc_entry_t    ent_q [2][N];
  xlc_entry_t    ent_d [2][N];

  logic [IDX_W-1:0] rq_idx;
  logic             idle, pr_ok, pr_fault;
  logic [AW-1:0]    pr_phys;
  xlc_entry_t       fill_ent;
  logic [1:0][N-1:0] glob_bits, clr;
  logic unused_faddr, unused_tc;

  assign unused_faddr = ^{flush_addr[AW-1:XLC_PG_SHIFT+IDX_W], flush_addr[XLC_PG_SHIFT-1:0]};
  assign unused_tc    = ^tc_wdata[13:0];
  assign rq_idx    = rq_addr_q[XLC_PG_SHIFT +: IDX_W];
  assign idle      = (state_q == XS_IDLE);
  assign req_ready = idle & ~tc_wr & ~flush_valid;
  assign walk_req  = (state_q == XS_WALK);
  assign walk_addr = rq_addr_q;
  assign walk_super = rq_super_q;
  assign walk_data  = rq_data_q;
  assign walk_write = rq_write_q;
  assign resp_valid = rsp_v_q;
  assign resp_hit   = rsp_hit_q;
  assign resp_fault = rsp_flt_q;
  assign resp_phys  = rsp_phys_q;

  always_comb begin
    for (int b = 0; b < 2; b++)
      for (int i = 0; i < N; i++)
        glob_bits[b][i] = ent_q[b][i].glob;
  end

  xlc_probe i_probe (
    .ent(ent_q[rq_super_q][rq_idx]), .addr(rq_addr_q), .is_data(rq_data_q),
    .is_write(rq_write_q), .done_ok(pr_ok), .done_fault(pr_fault), .phys(pr_phys)
  );

  xlc_fill i_fill (
    .paging_on(paging_q), .page8k(p8_q), .is_super(rq_super_q), .is_data(rq_data_q),
    .lpn(rq_addr_q[AW-1:XLC_PG_SHIFT]), .win_hit(walk_win_hit), .win_wp(walk_win_wp),
    .win_other(walk_win_other), .desc(walk_desc), .ent(fill_ent)
  );

  xlc_flush_mask #(.IDX_W(IDX_W)) i_flush (
    .apply(idle & (tc_wr | flush_valid)), .all(tc_wr | flush_all),
    .with_glob(tc_wr | flush_global), .bank(flush_super),
    .idx(flush_addr[XLC_PG_SHIFT +: IDX_W]), .page8k(p8_q),
    .glob(glob_bits), .clr(clr)
  );

  // next state
  always_comb begin
    state_d    = state_q;
    rq_addr_d  = rq_addr_q;
    rq_super_d = rq_super_q;
    rq_data_d  = rq_data_q;
    rq_write_d = rq_write_q;
    walked_d   = walked_q;
    paging_d   = paging_q;
    p8_d       = p8_q;
    rsp_v_d    = 1'b0;
    rsp_hit_d  = rsp_hit_q;
    rsp_flt_d  = rsp_flt_q;
    rsp_phys_d = rsp_phys_q;
    ent_d      = ent_q;
    for (int b = 0; b < 2; b++)
      for (int i = 0; i < N; i++)
        if (clr[b][i]) ent_d[b][i].tag = XLC_TAG_EMPTY;
    case (state_q)
      XS_IDLE: begin
        if (tc_wr) begin
          paging_d = tc_wdata[15];
          p8_d     = tc_wdata[14];
        end else if (!flush_valid && req_valid) begin
          rq_addr_d  = req_addr;
          rq_super_d = req_super;
          rq_data_d  = req_data;
          rq_write_d = req_write;
          walked_d   = 1'b0;
          state_d    = XS_LOOK;
        end
      end
      XS_LOOK: begin
        if (pr_ok || pr_fault) begin
          rsp_v_d    = 1'b1;
          rsp_hit_d  = ~walked_q;
          rsp_flt_d  = pr_fault;
          rsp_phys_d = pr_fault ? '0 : pr_phys;
          state_d    = XS_IDLE;
        end else begin
          state_d = XS_WALK;
        end
      end
      XS_WALK: begin
        if (walk_done) begin
          ent_d[rq_super_q][rq_idx] = fill_ent;
          walked_d = 1'b1;
          state_d  = XS_LOOK;
        end
      end
      default: state_d = XS_IDLE;
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      state_q    <= XS_IDLE;
      rq_addr_q  <= '0;
      rq_super_q <= 1'b0;
      rq_data_q  <= 1'b0;
      rq_write_q <= 1'b0;
      walked_q   <= 1'b0;
      paging_q   <= 1'b0;
      p8_q       <= 1'b0;
      rsp_v_q    <= 1'b0;
      rsp_hit_q  <= 1'b0;
      rsp_flt_q  <= 1'b0;
      rsp_phys_q <= '0;
      for (int b = 0; b < 2; b++)
        for (int i = 0; i < N; i++)
          ent_q[b][i] <= XLC_ENT_EMPTY;
    end else begin
      state_q    <= state_d;
      rq_addr_q  <= rq_addr_d;
      rq_super_q <= rq_super_d;
      rq_data_q  <= rq_data_d;
      rq_write_q <= rq_write_d;
      walked_q   <= walked_d;
      paging_q   <= paging_d;
      p8_q       <= p8_d;
      rsp_v_q    <= rsp_v_d;
      rsp_hit_q  <= rsp_hit_d;
      rsp_flt_q  <= rsp_flt_d;
      rsp_phys_q <= rsp_phys_d;
      for (int b = 0; b < 2; b++)
        for (int i = 0; i < N; i++)
          ent_q[b][i] <= ent_d[b][i];
    end
  end

  // assertions
  logic all_empty;
  always_comb begin
    all_empty = 1'b1;
    for (int b = 0; b < 2; b++)
      for (int i = 0; i < N; i++)
        if (ent_q[b][i].tag != XLC_TAG_EMPTY) all_empty = 1'b0;
  end

  AST_WALK_HOLD: assert property (@(posedge clk) disable iff (!rst_n_s)
    walk_req && !walk_done |=> walk_req); // R2
  AST_NO_ACCEPT_WALKING: assert property (@(posedge clk) disable iff (!rst_n_s)
    req_ready |-> !walk_req); // R2
  AST_HIT_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n_s)
    resp_valid && resp_hit |-> $past(state_q) == XS_LOOK && $past(state_q, 2) == XS_IDLE); // R3
  AST_FAULT_NO_ADDR: assert property (@(posedge clk) disable iff (!rst_n_s)
    resp_valid && resp_fault |-> resp_phys == '0); // R7
  AST_TC_EMPTIES_ALL: assert property (@(posedge clk) disable iff (!rst_n_s)
    $past(tc_wr && state_q == XS_IDLE) |-> all_empty); // R13

  for (genvar b = 0; b < 2; b++) begin : g_chk_b
    for (genvar i = 0; i < N; i++) begin : g_chk_i
      AST_GLOBAL_SPARED: assert property (@(posedge clk) disable iff (!rst_n_s)
        idle && !tc_wr && flush_valid && !flush_global && ent_q[b][i].glob &&
        ent_q[b][i].tag != XLC_TAG_EMPTY
        |=> ent_q[b][i].tag == $past(ent_q[b][i].tag)); // R10
    end
  end
endmodule

// File: tb/test_xlate_cache.sv
module test_xlate_cache;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        tc_wr;
  logic [15:0] tc_wdata;
  logic        flush_valid, flush_all, flush_global, flush_super;
  logic [31:0] flush_addr;
  logic        req_valid, req_ready, req_super, req_data, req_write;
  logic [31:0] req_addr;
  logic        resp_valid, resp_hit, resp_fault;
  logic [31:0] resp_phys;
  logic        walk_req, walk_super, walk_data, walk_write;
  logic [31:0] walk_addr;
  logic        walk_done, walk_win_hit, walk_win_wp, walk_win_other;
  logic [31:0] walk_desc;

  logic [31:0] cfg_desc;
  logic        cfg_win, cfg_win_wp, cfg_win_other;
  int walks = 0;
  int n_chk = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  xlate_cache i_xlate_cache (.*);

  // walker model
  initial begin
    walk_done = 1'b0; walk_win_hit = 1'b0; walk_win_wp = 1'b0;
    walk_win_other = 1'b0; walk_desc = '0;
    forever begin
      @(negedge clk);
      if (walk_req && !walk_done) begin
        walks++;
        repeat (2) @(negedge clk);
        walk_done      = 1'b1;
        walk_win_hit   = cfg_win;
        walk_win_wp    = cfg_win_wp;
        walk_win_other = cfg_win_other;
        walk_desc      = cfg_desc | ((walk_write && cfg_desc[0] && !cfg_desc[2]) ? 32'h10 : 32'h0);
        @(negedge clk);
        walk_done = 1'b0;
      end
    end
  end

  task automatic chk(input string rq, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", rq, what, act, exp);
    end
  endtask

  task automatic acc(input logic [31:0] a, input logic s, input logic d, input logic w,
                     output logic [31:0] ph, output logic flt, output logic hit,
                     output int nw, output int lat);
    int w0;
    w0 = walks;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_addr = a; req_super = s; req_data = d; req_write = w;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    lat = 0;
    while (!resp_valid && lat < 200) begin
      @(negedge clk);
      lat++;
    end
    ph = resp_phys; flt = resp_fault; hit = resp_hit;
    nw = walks - w0;
  endtask

  task automatic expect_acc(input string rq, input logic [31:0] a, input logic s, input logic d,
                            input logic w, input logic exp_flt, input logic [31:0] exp_ph,
                            input int exp_walks);
    logic [31:0] ph; logic flt, hit; int nw, lat;
    acc(a, s, d, w, ph, flt, hit, nw, lat);
    chk(rq, "fault", {31'b0, flt}, {31'b0, exp_flt});
    if (!exp_flt) chk(rq, "phys", ph, exp_ph);
    else          chk(rq, "phys on fault", ph, 32'h0);
    chk(rq, "walks", nw, exp_walks);
    chk(rq, "hit", {31'b0, hit}, {31'b0, exp_walks == 0});
    if (exp_walks == 0) chk(rq, "latency", lat, 1);
  endtask

  task automatic tc_write(input logic [15:0] v);
    @(negedge clk);
    tc_wr = 1'b1; tc_wdata = v;
    @(negedge clk);
    tc_wr = 1'b0;
  endtask

  task automatic flush(input logic all, input logic glob, input logic sup, input logic [31:0] a);
    @(negedge clk);
    flush_valid = 1'b1; flush_all = all; flush_global = glob; flush_super = sup; flush_addr = a;
    @(negedge clk);
    flush_valid = 1'b0;
  endtask

  task automatic set_desc(input logic [31:0] dsc);
    cfg_desc = dsc; cfg_win = 1'b0; cfg_win_wp = 1'b0; cfg_win_other = 1'b0;
  endtask

  task automatic t_reset;
    chk("R1", "req_ready", {31'b0, req_ready}, 32'h1);
    chk("R1", "resp_valid", {31'b0, resp_valid}, 32'h0);
    chk("R1", "walk_req", {31'b0, walk_req}, 32'h0);
  endtask

  task automatic t_disabled;
    set_desc(32'h0);
    expect_acc("R1", 32'h0001_2345, 1'b0, 1'b1, 1'b0, 1'b0, 32'h0001_2345, 1);
    expect_acc("R3", 32'h0001_2345, 1'b0, 1'b1, 1'b0, 1'b0, 32'h0001_2345, 0);
    expect_acc("R4", 32'h0001_2345, 1'b0, 1'b1, 1'b1, 1'b0, 32'h0001_2345, 0);
    expect_acc("R4", 32'h0001_2ABC, 1'b0, 1'b0, 1'b0, 1'b0, 32'h0001_2ABC, 0);
  endtask

  task automatic t_desc_fill;
    tc_write(16'h8000);
    set_desc(32'h0040_0001);
    expect_acc("R13", 32'h0001_2345, 1'b0, 1'b1, 1'b0, 1'b0, 32'h0040_0345, 1);
    expect_acc("R6", 32'h0001_2345, 1'b0, 1'b1, 1'b0, 1'b0, 32'h0040_0345, 0);
    expect_acc("R9", 32'h0001_2345, 1'b0, 1'b1, 1'b1, 1'b0, 32'h0040_0345, 1);
    expect_acc("R9", 32'h0001_2346, 1'b0, 1'b1, 1'b1, 1'b0, 32'h0040_0346, 0);
  endtask

  task automatic t_write_protect;
    tc_write(16'h8000);
    set_desc(32'h0050_0005);
    expect_acc("R6", 32'h0002_0000, 1'b0, 1'b1, 1'b0, 1'b0, 32'h0050_0000, 1);
    expect_acc("R8", 32'h0002_0010, 1'b0, 1'b1, 1'b1, 1'b1, 32'h0, 0);
  endtask

  task automatic t_residency;
    tc_write(16'h8000);
    set_desc(32'h0);
    expect_acc("R7", 32'h0003_0000, 1'b0, 1'b1, 1'b0, 1'b1, 32'h0, 1);
    set_desc(32'h0060_0081);
    expect_acc("R7", 32'h0004_0000, 1'b0, 1'b1, 1'b0, 1'b1, 32'h0, 1);
    expect_acc("R14", 32'h0004_0000, 1'b1, 1'b1, 1'b0, 1'b0, 32'h0060_0000, 1);
    expect_acc("R14", 32'h0004_0004, 1'b0, 1'b1, 1'b0, 1'b1, 32'h0, 0);
  endtask

  task automatic t_window;
    tc_write(16'h8000);
    set_desc(32'h0);
    cfg_win = 1'b1; cfg_win_wp = 1'b1; cfg_win_other = 1'b0;
    expect_acc("R5", 32'h0005_0010, 1'b0, 1'b1, 1'b0, 1'b0, 32'h0005_0010, 1);
    expect_acc("R5", 32'h0005_0010, 1'b0, 1'b1, 1'b1, 1'b1, 32'h0, 0);
    expect_acc("R5", 32'h0005_0010, 1'b0, 1'b0, 1'b0, 1'b1, 32'h0, 0);
    set_desc(32'h0);
  endtask

  task automatic t_flush_addr;
    tc_write(16'h8000);
    set_desc(32'h0070_0401);
    expect_acc("R10", 32'h0007_0000, 1'b0, 1'b1, 1'b0, 1'b0, 32'h0070_0000, 1);
    set_desc(32'h0080_0001);
    expect_acc("R10", 32'h0008_0000, 1'b0, 1'b1, 1'b0, 1'b0, 32'h0080_0000, 1);
    flush(1'b0, 1'b0, 1'b0, 32'h0007_0000);
    expect_acc("R10", 32'h0007_0000, 1'b0, 1'b1, 1'b0, 1'b0, 32'h0070_0000, 0);
    flush(1'b0, 1'b0, 1'b0, 32'h0008_0000);
    expect_acc("R10", 32'h0008_0000, 1'b0, 1'b1, 1'b0, 1'b0, 32'h0080_0000, 1);
    set_desc(32'h0070_0401);
    flush(1'b0, 1'b1, 1'b0, 32'h0007_0000);
    expect_acc("R10", 32'h0007_0000, 1'b0, 1'b1, 1'b0, 1'b0, 32'h0070_0000, 1);
    flush(1'b0, 1'b1, 1'b1, 32'h0008_0000);
    expect_acc("R14", 32'h0008_0000, 1'b0, 1'b1, 1'b0, 1'b0, 32'h0080_0000, 0);
  endtask

  task automatic t_flush_all;
    tc_write(16'h8000);
    set_desc(32'h0080_0001);
    expect_acc("R12", 32'h0008_0000, 1'b0, 1'b1, 1'b0, 1'b0, 32'h0080_0000, 1);
    set_desc(32'h0090_0001);
    expect_acc("R12", 32'h0009_0000, 1'b1, 1'b1, 1'b0, 1'b0, 32'h0090_0000, 1);
    set_desc(32'h0070_0401);
    expect_acc("R12", 32'h0007_0000, 1'b0, 1'b1, 1'b0, 1'b0, 32'h0070_0000, 1);
    flush(1'b1, 1'b0, 1'b0, 32'h0);
    expect_acc("R12", 32'h0007_0000, 1'b0, 1'b1, 1'b0, 1'b0, 32'h0070_0000, 0);
    set_desc(32'h0080_0001);
    expect_acc("R12", 32'h0008_0000, 1'b0, 1'b1, 1'b0, 1'b0, 32'h0080_0000, 1);
    set_desc(32'h0090_0001);
    expect_acc("R12", 32'h0009_0000, 1'b1, 1'b1, 1'b0, 1'b0, 32'h0090_0000, 1);
    set_desc(32'h0070_0401);
    flush(1'b1, 1'b1, 1'b0, 32'h0);
    expect_acc("R12", 32'h0007_0000, 1'b0, 1'b1, 1'b0, 1'b0, 32'h0070_0000, 1);
  endtask

  task automatic t_big_pages;
    tc_write(16'hC000);
    set_desc(32'h00B0_0001);
    expect_acc("R6", 32'h000A_1234, 1'b0, 1'b1, 1'b0, 1'b0, 32'h00B0_1234, 1);
    set_desc(32'h00C0_0001);
    expect_acc("R11", 32'h000A_2000, 1'b0, 1'b1, 1'b0, 1'b0, 32'h00C0_0000, 1);
    flush(1'b0, 1'b0, 1'b0, 32'h000A_3000);
    expect_acc("R11", 32'h000A_1234, 1'b0, 1'b1, 1'b0, 1'b0, 32'h00B0_1234, 0);
    expect_acc("R11", 32'h000A_2000, 1'b0, 1'b1, 1'b0, 1'b0, 32'h00C0_0000, 1);
  endtask

  task automatic t_walk_port;
    logic seen;
    tc_write(16'h8000);
    set_desc(32'h00D0_0001);
    @(negedge clk);
    req_valid = 1'b1; req_addr = 32'h000D_0040; req_super = 1'b1; req_data = 1'b0; req_write = 1'b0;
    @(negedge clk);
    req_valid = 1'b0;
    seen = 1'b0;
    for (int k = 0; k < 4 && !seen; k++) begin
      @(negedge clk);
      if (walk_req) seen = 1'b1;
    end
    chk("R2", "walk_req", {31'b0, seen}, 32'h1);
    chk("R2", "walk_addr", walk_addr, 32'h000D_0040);
    chk("R2", "walk flags", {29'b0, walk_super, walk_data, walk_write}, 32'h4);
    chk("R2", "ready while walking", {31'b0, req_ready}, 32'h0);
    while (!resp_valid) @(negedge clk);
    chk("R2", "phys after walk", resp_phys, 32'h00D0_0040);
  endtask

  initial begin
    rst_n = 1'b0; tc_wr = 1'b0; tc_wdata = '0; flush_valid = 1'b0; flush_all = 1'b0;
    flush_global = 1'b0; flush_super = 1'b0; flush_addr = '0; req_valid = 1'b0;
    req_addr = '0; req_super = 1'b0; req_data = 1'b0; req_write = 1'b0;
    set_desc(32'h0);
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_disabled();
    t_desc_fill();
    t_write_protect();
    t_residency();
    t_window();
    t_flush_addr();
    t_flush_all();
    t_big_pages();
    t_walk_port();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule